// File: doc/BRIEF.md
# Power-Up Strap Latch Sequencer

This block brings a clock generator out of power-on reset in a fixed order. It first waits for the internal supply-good indication. It then captures the mode strap pins on the first reference-clock edge at which the active-low sampling strobe is seen low. From that moment it runs two timed waits: the first ends by enabling the PLL, and the second ends by enabling the clock outputs. The captured straps are held until the next power-on reset.

The captured straps are decoded into one operating mode. The first mode runs from internally generated 66/33 MHz clocks. The second makes the 66 MHz group repeat an external 66 MHz input. The third parks every output in high impedance. The fourth is a test mode, where each output is a fixed power-of-two division of an externally driven test clock. All test-mode divisions come from one synchronous counter on the test clock, so they stay phase-aligned. The three-level select pin arrives already resolved into a 2-bit code.

Top module: `pwrup_strap_seq`

## Requirements
- R1: While `rst_n` is low, `straps_valid`, `pll_en`, `out_en`, `ext_buf_mode`, `hiz_mode` and `test_mode` are 0, and `cpu_mhz` is 0.
- R2: While `pwr_good` has not been seen high, a low `strobe_n` captures nothing: `straps_valid` and `pll_en` stay 0.
- R3: Once `pwr_good` has been seen high, the straps are captured on the first rising `clk` edge that samples `strobe_n` low, and `straps_valid` rises after that edge. While `strobe_n` is high nothing is captured. Strap changes after the capture, including later strobe pulses, have no effect on any decoded output until the next reset.
- R4: `pll_en` rises exactly `PLL_DLY` `clk` cycles after the capture edge and stays high until reset.
- R5: `out_en` rises exactly `OUT_DLY` `clk` cycles after `pll_en` rises, never before it, and stays high until reset.
- R6: In the two frequency modes, `cpu_mhz` reports the CPU frequency selected by {`sel1`,`sel0`}: 00 gives 66, 01 gives 100, 10 gives 200 and 11 gives 133. In every other mode `cpu_mhz` is 0.
- R7: The three-level select code `sel2` is 2'b00 for low, 2'b01 for mid, 2'b10 for high, and 2'b11 counts as high. `ext_buf_mode` is 1 exactly when the captured code is high.
- R8: When the captured `sel2` is mid, `hiz_mode` is 1 if {`sel1`,`sel0`} is 00, 10 or 11.
- R9: When the captured `sel2` is mid and {`sel1`,`sel0`} is 01, `test_mode` is 1. At most one of `ext_buf_mode`, `hiz_mode` and `test_mode` is ever 1.
- R10: With `test_mode` and `out_en` both 1, {`tdiv_pci`,`tdiv_66`,`tdiv_cpu`} counts up in binary by one on each rising `tst_clk` edge. This gives CPU = tclk/2, 66 MHz group = tclk/4 and PCI = tclk/8. `tdiv_48` follows `tdiv_cpu`, `tdiv_sel` follows `tdiv_66`, and `tdiv_ref` follows `tst_clk`. In any other state all six test outputs are 0.
- R11: `mult_q` holds the value of `mult_sel` captured together with the other straps, and is 0 before the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; sequencing and strap capture |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| pwr_good | input | 1 | Internal supply-good indication |
| strobe_n | input | 1 | Active-low strap sampling strobe, level sensitive |
| sel2 | input | 2 | Three-level select, coded low/mid/high |
| sel1 | input | 1 | Frequency select, upper bit |
| sel0 | input | 1 | Frequency select, lower bit |
| mult_sel | input | 1 | Current-multiplier strap |
| tst_clk | input | 1 | Externally driven test clock |
| straps_valid | output | 1 | Straps have been captured |
| pll_en | output | 1 | PLL enable |
| out_en | output | 1 | Clock output enable |
| ext_buf_mode | output | 1 | 66 MHz group repeats the external input |
| hiz_mode | output | 1 | All outputs in high impedance |
| test_mode | output | 1 | Outputs derived from the test clock |
| cpu_mhz | output | 8 | Selected CPU frequency in MHz, 0 when none |
| mult_q | output | 1 | Captured current-multiplier strap |
| tdiv_cpu | output | 1 | Test clock divided by 2 for the CPU pairs |
| tdiv_66 | output | 1 | Test clock divided by 4 for the 66 MHz group |
| tdiv_pci | output | 1 | Test clock divided by 8 for PCI |
| tdiv_ref | output | 1 | Test clock passed to the reference output |
| tdiv_48 | output | 1 | Test clock divided by 2 for the 48 MHz pair |
| tdiv_sel | output | 1 | Test clock divided by 4 for the selectable output |

## Verification
Some properties are checked on every reference-clock cycle. The order of valid, PLL enable and output enable is one. The exact length of both waits, measured with counters in the checker, is another. The checker also covers the capture only from the armed state with a low strobe, the stability of every decoded output once captured, and the mutual exclusion of the three special modes. The rest needs the bench's scenarios to show. These are the decode of every select combination, including the spare high code. They also include the refusal to capture before supply-good, the indifference to later strap changes and strobe pulses, and the phase-aligned binary counting of the test-clock divisions in a second clock domain.

// File: rtl/pwrup_strap_pkg.sv
package pwrup_strap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_PLLW = 3'd2,
    ST_OUTW = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_t;

  typedef enum logic [2:0] {
    MODE_NONE = 3'd0,
    MODE_INT  = 3'd1,
    MODE_EXT  = 3'd2,
    MODE_HIZ  = 3'd3,
    MODE_TEST = 3'd4
  } op_mode_t;

  typedef struct packed {
    logic [1:0] lvl;
    logic       s1;
    logic       s0;
    logic       mult;
  } straps_t;

  localparam logic [1:0] LVL_LOW = 2'b00;
  localparam logic [1:0] LVL_MID = 2'b01;

  // Three-level select plus frequency bits to an operating mode.
  function automatic op_mode_t decode_mode(input logic [1:0] lvl,
                                           input logic s1, input logic s0);
    op_mode_t m;
    if (lvl == LVL_LOW)      m = MODE_INT;
    else if (lvl == LVL_MID) m = (!s1 && s0) ? MODE_TEST : MODE_HIZ;
    else                     m = MODE_EXT;
    return m;
  endfunction

  // CPU frequency in MHz for the frequency modes, 0 otherwise.
  function automatic logic [7:0] cpu_freq_mhz(input op_mode_t m,
                                              input logic s1, input logic s0);
    logic [7:0] f;
    case ({s1, s0})
      2'b00:   f = 8'd66;
      2'b01:   f = 8'd100;
      2'b10:   f = 8'd200;
      default: f = 8'd133;
    endcase
    if (m != MODE_INT && m != MODE_EXT) f = 8'd0;
    return f;
  endfunction

endpackage

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
  import pwrup_strap_pkg::*;
#(
  parameter int PLL_DLY = 16,
  parameter int OUT_DLY = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic strobe_n,
  output logic latch_pulse,
  output logic pll_en,
  output logic out_en
);
  localparam int MAX_DLY = (PLL_DLY > OUT_DLY) ? PLL_DLY : OUT_DLY;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] PLL_LAST = CNT_W'(PLL_DLY - 1);
  localparam logic [CNT_W-1:0] OUT_LAST = CNT_W'(OUT_DLY - 1);

  seq_state_t        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pll_d, out_d;
  logic              pll_done, out_done;

  assign latch_pulse = (st_q == ST_ARM) && !strobe_n;
  assign pll_done    = (cnt_q == PLL_LAST);
  assign out_done    = (cnt_q == OUT_LAST);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    pll_d = pll_en;
    out_d = out_en;
    case (st_q)
      ST_IDLE: if (pwr_good) st_d = ST_ARM;
      ST_ARM: begin
        if (latch_pulse) begin
          st_d  = ST_PLLW;
          cnt_d = '0;
        end
      end
      ST_PLLW: begin
        if (pll_done) begin
          st_d  = ST_OUTW;
          cnt_d = '0;
          pll_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_OUTW: begin
        if (out_done) begin
          st_d  = ST_RUN;
          cnt_d = '0;
          out_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pll_en <= 1'b0;
      out_en <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pll_en <= pll_d;
      out_en <= out_d;
    end
  end

endmodule

// File: rtl/pwrup_strap_latch.sv
module pwrup_strap_latch
  import pwrup_strap_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    latch_pulse,
  input  straps_t straps_in,
  output straps_t straps_q,
  output logic    valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      straps_q <= '0;
      valid    <= 1'b0;
    end else if (latch_pulse && !valid) begin
      straps_q <= straps_in;
      valid    <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrup_mode_dec.sv
module pwrup_mode_dec
  import pwrup_strap_pkg::*;
(
  input  straps_t    straps_q,
  input  logic       valid,
  output logic       ext_buf_mode,
  output logic       hiz_mode,
  output logic       test_mode,
  output logic [7:0] cpu_mhz,
  output logic       mult_q
);
  op_mode_t mode;

  always_comb begin
    mode = valid ? decode_mode(straps_q.lvl, straps_q.s1, straps_q.s0)
                 : MODE_NONE;
    ext_buf_mode = (mode == MODE_EXT);
    hiz_mode     = (mode == MODE_HIZ);
    test_mode    = (mode == MODE_TEST);
    cpu_mhz      = cpu_freq_mhz(mode, straps_q.s1, straps_q.s0);
    mult_q       = valid & straps_q.mult;
  end
endmodule

// File: rtl/pwrup_tclk_div.sv
module pwrup_tclk_div #(
  parameter int DIV_BITS  = 3,
  parameter int SYNC_LEN  = 2
) (
  input  logic                tst_clk,
  input  logic                rst_n,
  input  logic                run_req,
  output logic [DIV_BITS-1:0] div_o,
  output logic                tclk_o
);
  logic [SYNC_LEN-1:0] sync_q;
  logic                run_s;
  logic [DIV_BITS-1:0] cnt_q;

  always_ff @(posedge tst_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_LEN-2:0], run_req};
  end
  assign run_s = sync_q[SYNC_LEN-1];

  always_ff @(posedge tst_clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_s) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < DIV_BITS; i++) begin : g_tap
    assign div_o[i] = cnt_q[i] & run_s;
  end

  assign tclk_o = tst_clk & run_s;
endmodule

// File: rtl/pwrup_strap_seq.sv
module pwrup_strap_seq
  import pwrup_strap_pkg::*;
#(
  parameter int PLL_DLY = 16,
  parameter int OUT_DLY = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       strobe_n,
  input  logic [1:0] sel2,
  input  logic       sel1,
  input  logic       sel0,
  input  logic       mult_sel,
  input  logic       tst_clk,
  output logic       straps_valid,
  output logic       pll_en,
  output logic       out_en,
  output logic       ext_buf_mode,
  output logic       hiz_mode,
  output logic       test_mode,
  output logic [7:0] cpu_mhz,
  output logic       mult_q,
  output logic       tdiv_cpu,
  output logic       tdiv_66,
  output logic       tdiv_pci,
  output logic       tdiv_ref,
  output logic       tdiv_48,
  output logic       tdiv_sel
);
  localparam int DIV_BITS = 3;

  logic                latch_pulse;
  straps_t             straps_in, straps_q;
  logic                test_run;
  logic [DIV_BITS-1:0] div_w;

  assign straps_in = '{lvl: sel2, s1: sel1, s0: sel0, mult: mult_sel};

  pwrup_seq_fsm #(.PLL_DLY(PLL_DLY), .OUT_DLY(OUT_DLY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strobe_n(strobe_n),
    .latch_pulse(latch_pulse), .pll_en(pll_en), .out_en(out_en)
  );

  pwrup_strap_latch u_latch (
    .clk(clk), .rst_n(rst_n), .latch_pulse(latch_pulse),
    .straps_in(straps_in), .straps_q(straps_q), .valid(straps_valid)
  );

  pwrup_mode_dec u_dec (
    .straps_q(straps_q), .valid(straps_valid),
    .ext_buf_mode(ext_buf_mode), .hiz_mode(hiz_mode), .test_mode(test_mode),
    .cpu_mhz(cpu_mhz), .mult_q(mult_q)
  );

  assign test_run = test_mode & out_en;

  pwrup_tclk_div #(.DIV_BITS(DIV_BITS), .SYNC_LEN(2)) u_div (
    .tst_clk(tst_clk), .rst_n(rst_n), .run_req(test_run),
    .div_o(div_w), .tclk_o(tdiv_ref)
  );

  assign tdiv_cpu = div_w[0];
  assign tdiv_66  = div_w[1];
  assign tdiv_pci = div_w[2];
  assign tdiv_48  = div_w[0];
  assign tdiv_sel = div_w[1];

endmodule

// File: rtl/pwrup_strap_seq_chk.sv
module pwrup_strap_seq_chk #(
  parameter int PLL_DLY = 16,
  parameter int OUT_DLY = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       strobe_n,
  input logic       latch_pulse,
  input logic       straps_valid,
  input logic       pll_en,
  input logic       out_en,
  input logic       ext_buf_mode,
  input logic       hiz_mode,
  input logic       test_mode,
  input logic [7:0] cpu_mhz,
  input logic       mult_q
);
  logic [31:0] pll_wait, out_wait;
  logic        pg_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_wait <= '0;
      out_wait <= '0;
      pg_seen  <= 1'b0;
    end else begin
      if (pwr_good) pg_seen <= 1'b1;
      if (straps_valid && !pll_en) pll_wait <= pll_wait + 1;
      if (pll_en && !out_en)       out_wait <= out_wait + 1;
    end
  end

  assert_latch_needs_pg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |-> pg_seen);
  assert_latch_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(straps_valid) |-> !$past(strobe_n));
  assert_hold_after_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (straps_valid && $past(straps_valid)) |->
      ($stable(cpu_mhz) && $stable(ext_buf_mode) && $stable(hiz_mode)
       && $stable(test_mode) && $stable(mult_q)));
  assert_pll_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> straps_valid);
  assert_pll_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> (pll_wait == PLL_DLY));
  assert_pll_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pll_en) |-> pll_en);
  assert_out_after_pll_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> pll_en);
  assert_out_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> (out_wait == OUT_DLY));
  assert_out_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(out_en) |-> out_en);
  assert_freq_only_normal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz_mode || test_mode || !straps_valid) |-> (cpu_mhz == 8'd0));
  assert_mode_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_buf_mode, hiz_mode, test_mode}));
  assert_mult_before_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !straps_valid |-> !mult_q);
endmodule

bind pwrup_strap_seq pwrup_strap_seq_chk #(.PLL_DLY(PLL_DLY), .OUT_DLY(OUT_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strobe_n(strobe_n),
  .latch_pulse(latch_pulse), .straps_valid(straps_valid), .pll_en(pll_en),
  .out_en(out_en), .ext_buf_mode(ext_buf_mode), .hiz_mode(hiz_mode),
  .test_mode(test_mode), .cpu_mhz(cpu_mhz), .mult_q(mult_q)
);

// File: tb/pwrup_strap_seq_bench.sv
module pwrup_strap_seq_bench;
  localparam int PLL_D = 16;
  localparam int OUT_D = 48;

  logic       clk = 1'b0, tst_clk = 1'b0;
  logic       rst_n, pwr_good, strobe_n, sel1, sel0, mult_sel;
  logic [1:0] sel2;
  logic       straps_valid, pll_en, out_en, ext_buf_mode, hiz_mode, test_mode;
  logic [7:0] cpu_mhz;
  logic       mult_q, tdiv_cpu, tdiv_66, tdiv_pci, tdiv_ref, tdiv_48, tdiv_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always #7 tst_clk = ~tst_clk;

  pwrup_strap_seq #(.PLL_DLY(PLL_D), .OUT_DLY(OUT_D)) u_pwrup_strap_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strobe_n(strobe_n),
    .sel2(sel2), .sel1(sel1), .sel0(sel0), .mult_sel(mult_sel), .tst_clk(tst_clk),
    .straps_valid(straps_valid), .pll_en(pll_en), .out_en(out_en),
    .ext_buf_mode(ext_buf_mode), .hiz_mode(hiz_mode), .test_mode(test_mode),
    .cpu_mhz(cpu_mhz), .mult_q(mult_q), .tdiv_cpu(tdiv_cpu), .tdiv_66(tdiv_66),
    .tdiv_pci(tdiv_pci), .tdiv_ref(tdiv_ref), .tdiv_48(tdiv_48), .tdiv_sel(tdiv_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected values restated from the requirements.
  function automatic int want_mhz(input logic [1:0] l, input logic a, input logic b);
    int tbl[4] = '{66, 100, 200, 133};
    if (l == 2'b01) return 0;
    return tbl[{a, b}];
  endfunction
  function automatic bit want_ext(input logic [1:0] l);
    return l[1];
  endfunction
  function automatic bit want_test(input logic [1:0] l, input logic a, input logic b);
    return (l == 2'b01) && ({a, b} == 2'b01);
  endfunction
  function automatic bit want_hiz(input logic [1:0] l, input logic a, input logic b);
    return (l == 2'b01) && !want_test(l, a, b);
  endfunction

  task automatic check_decode(input logic [1:0] l, input logic a, input logic b,
                              input logic m, input string tag);
    check(cpu_mhz == want_mhz(l, a, b), {"R6 ", tag}, cpu_mhz, want_mhz(l, a, b));
    check(ext_buf_mode == want_ext(l), {"R7 ", tag}, ext_buf_mode, want_ext(l));
    check(hiz_mode == want_hiz(l, a, b), {"R8 ", tag}, hiz_mode, want_hiz(l, a, b));
    check(test_mode == want_test(l, a, b), {"R9 ", tag}, test_mode, want_test(l, a, b));
    check(mult_q == m, {"R11 ", tag}, mult_q, m);
  endtask

  task automatic run_trial(input logic [1:0] l, input logic a, input logic b,
                           input logic m);
    int k;
    logic [2:0] prev, cur;
    rst_n = 1'b0; pwr_good = 1'b0; strobe_n = 1'b1;
    sel2 = l; sel1 = a; sel0 = b; mult_sel = m;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!straps_valid && !pll_en && !out_en, "R1 seq outputs", {straps_valid, pll_en, out_en}, 0);
    check(!ext_buf_mode && !hiz_mode && !test_mode && cpu_mhz == 0, "R1 mode outputs",
          cpu_mhz, 0);
    rst_n = 1'b1;
    // R2: strobe low before power good
    strobe_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!straps_valid && !pll_en, "R2 no capture before power good", straps_valid, 0);
    strobe_n = 1'b1; pwr_good = 1'b1;
    repeat (3) @(negedge clk);
    check(!straps_valid, "R3 no capture while strobe high", straps_valid, 0);
    strobe_n = 1'b0;
    @(negedge clk);
    check(straps_valid, "R3 capture on strobe", straps_valid, 1);
    strobe_n = 1'b1;
    sel2 = ~l; sel1 = ~a; sel0 = ~b; mult_sel = ~m;
    check_decode(l, a, b, m, "after capture");
    k = 0;
    while (!pll_en && k < 1000) begin @(negedge clk); k++; end
    check(k == PLL_D, "R4 pll delay", k, PLL_D);
    check(!out_en, "R5 out not before pll", out_en, 0);
    k = 0;
    while (!out_en && k < 1000) begin @(negedge clk); k++; end
    check(k == OUT_D, "R5 out delay", k, OUT_D);
    // R3: later strobe pulse with other straps has no effect
    strobe_n = 1'b0;
    repeat (2) @(negedge clk);
    strobe_n = 1'b1;
    @(negedge clk);
    check_decode(l, a, b, m, "R3 after second strobe");
    check(pll_en && out_en, "R5 enables stay high", {pll_en, out_en}, 3);
    if (want_test(l, a, b)) begin
      repeat (4) @(negedge tst_clk);
      prev = {tdiv_pci, tdiv_66, tdiv_cpu};
      for (int i = 0; i < 24; i++) begin
        @(negedge tst_clk);
        cur = {tdiv_pci, tdiv_66, tdiv_cpu};
        check(cur == prev + 3'd1, "R10 binary division", cur, prev + 3'd1);
        check(tdiv_48 == tdiv_cpu && tdiv_sel == tdiv_66, "R10 shared taps",
              {tdiv_48, tdiv_sel}, {tdiv_cpu, tdiv_66});
        check(!tdiv_ref, "R10 ref low with tclk low", tdiv_ref, 0);
        prev = cur;
        @(posedge tst_clk); #2;
        check(tdiv_ref, "R10 ref high with tclk high", tdiv_ref, 1);
      end
    end else begin
      for (int i = 0; i < 10; i++) begin
        @(posedge tst_clk); #2;
        check({tdiv_cpu, tdiv_66, tdiv_pci, tdiv_ref, tdiv_48, tdiv_sel} == 6'b0,
              "R10 quiet outside test", {tdiv_cpu, tdiv_66, tdiv_pci}, 0);
      end
    end
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; pwr_good = 1'b0; strobe_n = 1'b1;
    sel2 = 2'b00; sel1 = 1'b0; sel0 = 1'b0; mult_sel = 1'b0;
    r = $urandom(32'h5EED_0123);
    for (int l = 0; l < 4; l++)
      for (int f = 0; f < 4; f++)
        run_trial(2'(l), f[1], f[0], (l + f) % 2 == 1);
    for (int t = 0; t < 6; t++) begin
      r = $urandom;
      run_trial(r[1:0], r[2], r[3], r[4]);
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule